// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

A clocked controller that sits between a simple request/response host port and an asynchronous static RAM with 256K byte-wide locations. The RAM side has an 18-bit address, an 8-bit data bus split into output, output-enable and input halves for the pad ring, and active-low chip select, write enable and output enable. Every RAM interval is a whole number of system clocks set by parameters. The defaults are rounded up from the nanosecond minimums of the fastest speed grade at a 100 MHz clock.

The host offers a request with valid/ready, a write flag, an address and write data. Read data comes back with a one-clock valid pulse. For each write, a mode input chooses which strobe ends the write: write enable rising while chip select is still low, or chip select rising while write enable is still low. A retention request parks the RAM in standby with chip select high. When the request is withdrawn, the controller waits out a recovery interval before it accepts the next access.

Top module: `sram_ctl`

## Requirements
- R1: While reset is active and in the first cycle after it, chip select, write enable and output enable are high, the data bus is not driven, no response is flagged and ready is high.
- R2: A read holds chip select and output enable low, write enable high and the address steady for exactly RD_CYC clocks after acceptance. It samples the RAM data at the RD_CYC-th edge and flags it with a single-clock rsp_valid_o at that edge.
- R3: A write holds chip select and write enable both low for exactly WP_CYC clocks. It drives the write data from the acceptance edge, and address and data stay steady until both strobes are high again.
- R4: When wr_cs_end_i is 0 at acceptance, write enable rises first while chip select stays low. Chip select rises WT_CYC clocks later, where WT_CYC = max(1, WC_CYC - WP_CYC).
- R5: When wr_cs_end_i is 1 at acceptance, chip select rises first while write enable stays low. Write enable rises WT_CYC clocks later.
- R6: The data bus is driven only while write enable or chip select is low for a write, and never while output enable is low.
- R7: A write request is accepted no sooner than TA_CYC+1 edges after a read response edge (TA_CYC >= 1). A read request presented in the response cycle is accepted at the very next edge.
- R8: After a write is accepted at edge A, the next request is accepted no earlier than edge A + WP_CYC + WT_CYC + 1.
- R9: While ret_req_i is high and no access is in flight, ready is low and all three strobes are high. The retention request outranks a pending host request. An access in flight when retention is requested completes normally.
- R10: After ret_req_i is first seen low at edge D, chip select stays high and ready stays low for REC_CYC further clocks. The earliest acceptance is edge D + REC_CYC + 1.
- R11: Ready is high only while all strobes are high and the bus is undriven. A request is taken at an edge where valid and ready are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Controller can take a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Request address |
| req_wdata_i | input | DW | Write data |
| wr_cs_end_i | input | 1 | Write end style: 0 write enable ends, 1 chip select ends |
| rsp_valid_o | output | 1 | Read data valid, one clock |
| rsp_rdata_o | output | DW | Read data |
| ret_req_i | input | 1 | Retention (standby) request |
| ram_addr_o | output | AW | RAM address |
| ram_dq_o | output | DW | RAM write data to pad |
| ram_dq_oe_o | output | 1 | RAM data pad drive enable |
| ram_dq_i | input | DW | RAM data from pad |
| ram_cs_no | output | 1 | RAM chip select, active low |
| ram_we_no | output | 1 | RAM write enable, active low |
| ram_oe_no | output | 1 | RAM output enable, active low |

## Verification
The bench records the edge number at which each request is accepted and derives from it the edge at which each result is due. A read response is due RD_CYC edges later. A following write is due TA_CYC+1 edges after the response, and a following read one edge after it. A request after a write is due WP_CYC+WT_CYC+1 edges after that write's acceptance, and the first access after retention REC_CYC+2 edges after the bench lowers the request. Inputs change and outputs are sampled on the falling edge, so each check reads the state that the preceding rising edge produced. The RAM model returns valid data only after the read strobes and address have been steady for RD_CYC clocks, and it commits a write only when the strobe pulse ends. A controller that samples early or cuts the pulse short therefore shows wrong data or a pulse of the wrong length.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_WP, ST_WT, ST_RET, ST_REC
  } st_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_ctl_cnt.sv
module sram_ctl_cnt #(
  parameter int CW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int          CW     = 2,
  parameter logic [CW-1:0] RD_LD  = '0,
  parameter logic [CW-1:0] WP_LD  = '0,
  parameter logic [CW-1:0] WT_LD  = '0,
  parameter logic [CW-1:0] REC_LD = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic          ret_req_i,
  input  logic          ph_zero_i,
  input  logic          turn_zero_i,
  output logic          req_ready_o,
  output logic          ph_ld_o,
  output logic [CW-1:0] ph_val_o,
  output logic          turn_ld_o,
  output logic          rd_start_o,
  output logic          wr_start_o,
  output logic          rd_done_o,
  output logic          wr_mid_o,
  output logic          wr_done_o
);
  st_e st_q, st_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  always_comb begin
    st_d        = st_q;
    req_ready_o = 1'b0;
    ph_ld_o     = 1'b0;
    ph_val_o    = '0;
    turn_ld_o   = 1'b0;
    rd_start_o  = 1'b0;
    wr_start_o  = 1'b0;
    rd_done_o   = 1'b0;
    wr_mid_o    = 1'b0;
    wr_done_o   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        // writes wait out the read-to-write turnaround
        req_ready_o = !ret_req_i && (!req_write_i || turn_zero_i);
        if (ret_req_i) begin
          st_d = ST_RET;
        end else if (req_valid_i && req_ready_o) begin
          ph_ld_o = 1'b1;
          if (req_write_i) begin
            st_d       = ST_WP;
            ph_val_o   = WP_LD;
            wr_start_o = 1'b1;
          end else begin
            st_d       = ST_RD;
            ph_val_o   = RD_LD;
            rd_start_o = 1'b1;
          end
        end
      end
      ST_RD: if (ph_zero_i) begin
        rd_done_o = 1'b1;
        turn_ld_o = 1'b1;
        st_d      = ST_IDLE;
      end
      ST_WP: if (ph_zero_i) begin
        wr_mid_o = 1'b1;
        ph_ld_o  = 1'b1;
        ph_val_o = WT_LD;
        st_d     = ST_WT;
      end
      ST_WT: if (ph_zero_i) begin
        wr_done_o = 1'b1;
        st_d      = ST_IDLE;
      end
      ST_RET: if (!ret_req_i) begin
        ph_ld_o  = 1'b1;
        ph_val_o = REC_LD;
        st_d     = ST_REC;
      end
      ST_REC: if (ph_zero_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/sram_ctl_io.sv
module sram_ctl_io #(
  parameter int AW = 18,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_start_i,
  input  logic          wr_start_i,
  input  logic          rd_done_i,
  input  logic          wr_mid_i,
  input  logic          wr_done_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic          wr_cs_end_i,
  input  logic [DW-1:0] ram_dq_i,
  output logic [AW-1:0] ram_addr_o,
  output logic [DW-1:0] ram_dq_o,
  output logic          ram_dq_oe_o,
  output logic          ram_cs_no,
  output logic          ram_we_no,
  output logic          ram_oe_no,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o
);
  logic cs_end_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ram_addr_o  <= '0;
      ram_dq_o    <= '0;
      ram_dq_oe_o <= 1'b0;
      ram_cs_no   <= 1'b1;
      ram_we_no   <= 1'b1;
      ram_oe_no   <= 1'b1;
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
      cs_end_q    <= 1'b0;
    end else begin
      rsp_valid_o <= 1'b0;
      if (rd_start_i) begin
        ram_addr_o <= req_addr_i;
        ram_cs_no  <= 1'b0;
        ram_oe_no  <= 1'b0;
      end
      if (wr_start_i) begin
        ram_addr_o  <= req_addr_i;
        ram_dq_o    <= req_wdata_i;
        ram_dq_oe_o <= 1'b1;
        ram_cs_no   <= 1'b0;
        ram_we_no   <= 1'b0;
        cs_end_q    <= wr_cs_end_i;
      end
      if (rd_done_i) begin
        rsp_rdata_o <= ram_dq_i;
        rsp_valid_o <= 1'b1;
        ram_cs_no   <= 1'b1;
        ram_oe_no   <= 1'b1;
      end
      if (wr_mid_i) begin
        if (cs_end_q) ram_cs_no <= 1'b1;
        else          ram_we_no <= 1'b1;
      end
      if (wr_done_i) begin
        ram_cs_no   <= 1'b1;
        ram_we_no   <= 1'b1;
        ram_dq_oe_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int AW      = 18,
  parameter int DW      = 8,
  parameter int RD_CYC  = 2,
  parameter int WP_CYC  = 2,
  parameter int WC_CYC  = 2,
  parameter int TA_CYC  = 1,
  parameter int REC_CYC = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic          wr_cs_end_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  input  logic          ret_req_i,
  output logic [AW-1:0] ram_addr_o,
  output logic [DW-1:0] ram_dq_o,
  output logic          ram_dq_oe_o,
  input  logic [DW-1:0] ram_dq_i,
  output logic          ram_cs_no,
  output logic          ram_we_no,
  output logic          ram_oe_no
);
  localparam int WT_CYC = (WC_CYC > WP_CYC + 1) ? WC_CYC - WP_CYC : 1;
  localparam int MAXC   = imax(imax(imax(RD_CYC, WP_CYC), imax(WT_CYC, REC_CYC)), TA_CYC);
  localparam int CW     = $clog2(MAXC + 1);
  localparam logic [CW-1:0] RD_LD  = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] WP_LD  = CW'(WP_CYC - 1);
  localparam logic [CW-1:0] WT_LD  = CW'(WT_CYC - 1);
  localparam logic [CW-1:0] REC_LD = CW'(REC_CYC - 1);
  localparam logic [CW-1:0] TA_LD  = CW'(TA_CYC);

  logic          ph_ld, ph_zero, turn_ld, turn_zero;
  logic [CW-1:0] ph_val;
  logic          rd_start, wr_start, rd_done, wr_mid, wr_done;

  sram_ctl_fsm #(
    .CW(CW), .RD_LD(RD_LD), .WP_LD(WP_LD), .WT_LD(WT_LD), .REC_LD(REC_LD)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_write_i(req_write_i),
    .ret_req_i  (ret_req_i),
    .ph_zero_i  (ph_zero),
    .turn_zero_i(turn_zero),
    .req_ready_o(req_ready_o),
    .ph_ld_o    (ph_ld),
    .ph_val_o   (ph_val),
    .turn_ld_o  (turn_ld),
    .rd_start_o (rd_start),
    .wr_start_o (wr_start),
    .rd_done_o  (rd_done),
    .wr_mid_o   (wr_mid),
    .wr_done_o  (wr_done)
  );

  sram_ctl_cnt #(.CW(CW)) u_ph_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(ph_ld),
    .val_i (ph_val),
    .zero_o(ph_zero)
  );

  sram_ctl_cnt #(.CW(CW)) u_turn_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(turn_ld),
    .val_i (TA_LD),
    .zero_o(turn_zero)
  );

  sram_ctl_io #(.AW(AW), .DW(DW)) u_io (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_start_i (rd_start),
    .wr_start_i (wr_start),
    .rd_done_i  (rd_done),
    .wr_mid_i   (wr_mid),
    .wr_done_i  (wr_done),
    .req_addr_i (req_addr_i),
    .req_wdata_i(req_wdata_i),
    .wr_cs_end_i(wr_cs_end_i),
    .ram_dq_i   (ram_dq_i),
    .ram_addr_o (ram_addr_o),
    .ram_dq_o   (ram_dq_o),
    .ram_dq_oe_o(ram_dq_oe_o),
    .ram_cs_no  (ram_cs_no),
    .ram_we_no  (ram_we_no),
    .ram_oe_no  (ram_oe_no),
    .rsp_valid_o(rsp_valid_o),
    .rsp_rdata_o(rsp_rdata_o)
  );
endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_valid_i,
  input logic req_ready_o,
  input logic req_write_i,
  input logic rsp_valid_o,
  input logic ret_req_i,
  input logic ram_dq_oe_o,
  input logic ram_cs_no,
  input logic ram_we_no,
  input logic ram_oe_no
);
  // R6
  no_drive_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_dq_oe_o |-> ram_oe_no);

  // R6
  drive_in_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_dq_oe_o |-> (!ram_cs_no || !ram_we_no));

  // R3
  strobe_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_we_no |-> ram_dq_oe_o);

  // R2
  read_ctrl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_oe_no |-> (!ram_cs_no && ram_we_no));

  // R2
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  // R9
  ret_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_req_i && ram_cs_no && !req_ready_o) |=> ram_cs_no);

  // R11
  idle_pins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (ram_cs_no && ram_we_no && ram_oe_no && !ram_dq_oe_o));

  // R7
  turn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !(req_valid_i && req_ready_o && req_write_i));
endmodule

bind sram_ctl sram_ctl_chk u_chk (.*);

// File: tb/sram_ctl_tb.sv
module sram_ctl_tb;
  localparam int AW = 18, DW = 8;
  localparam int RD_CYC = 3, WP_CYC = 2, WC_CYC = 4, TA_CYC = 1, REC_CYC = 3;
  localparam int WT_CYC = (WC_CYC > WP_CYC + 1) ? WC_CYC - WP_CYC : 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, wr_cs_end = 1'b0, ret_req = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, dq_oe, cs_n, we_n, oe_n;
  logic [DW-1:0] rsp_rdata, dq_o;
  logic [DW-1:0] dq_i = 8'hEE;
  logic [AW-1:0] ram_addr;

  int cyc = 0, checks = 0, fails = 0;

  sram_ctl #(.AW(AW), .DW(DW), .RD_CYC(RD_CYC), .WP_CYC(WP_CYC), .WC_CYC(WC_CYC),
             .TA_CYC(TA_CYC), .REC_CYC(REC_CYC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .wr_cs_end_i(wr_cs_end), .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .ret_req_i(ret_req), .ram_addr_o(ram_addr), .ram_dq_o(dq_o), .ram_dq_oe_o(dq_oe),
    .ram_dq_i(dq_i), .ram_cs_no(cs_n), .ram_we_no(we_n), .ram_oe_no(oe_n));

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=0x%0h exp=0x%0h cyc=%0d", req, act, exp, cyc);
    end
  endtask

  function automatic logic [DW-1:0] dflt(input logic [AW-1:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  // RAM model: pin-level behaviour, updated on falling edges
  logic [DW-1:0] sram_mem [logic [AW-1:0]];
  logic [DW-1:0] exp_mem  [logic [AW-1:0]];
  int rd_age = 0;
  logic [AW-1:0] prev_addr = '0;
  bit in_wr = 0, wr_ok = 0;
  int wlen = 0;
  logic [AW-1:0] waddr = '0;
  logic [DW-1:0] wdat = '0;
  bit style_q[$];
  int due_q[$];
  logic [DW-1:0] dat_q[$];

  always @(negedge clk) begin
    if (rst_n) begin
      // read access timing
      if (!cs_n && !oe_n && we_n) rd_age = (rd_age > 0 && ram_addr == prev_addr) ? rd_age + 1 : 1;
      else rd_age = 0;
      prev_addr = ram_addr;
      if (rd_age >= RD_CYC)
        dq_i <= sram_mem.exists(ram_addr) ? sram_mem[ram_addr] : dflt(ram_addr);
      else dq_i <= 8'hEE;
      // write capture
      if (!cs_n && !we_n) begin
        if (!in_wr) begin
          in_wr = 1; wlen = 1; waddr = ram_addr; wdat = dq_o; wr_ok = dq_oe;
        end else begin
          wlen++;
          wr_ok = wr_ok && dq_oe && ram_addr == waddr && dq_o == wdat;
        end
      end else if (in_wr) begin
        bit sty;
        in_wr = 0;
        chk(wlen == WP_CYC, "R3 pulse length", wlen, WP_CYC);
        chk(wr_ok && dq_oe && dq_o == wdat && ram_addr == waddr, "R3 data/addr steady", dq_o, wdat);
        sty = (style_q.size() > 0) ? style_q.pop_front() : 1'b0;
        if (sty) chk(cs_n && !we_n, "R5 chip select ends write", {cs_n, we_n}, 2'b10);
        else     chk(!cs_n && we_n, "R4 write enable ends write", {cs_n, we_n}, 2'b01);
        sram_mem[waddr] = wdat;
      end
      // bus and handshake rules
      if (dq_oe) chk(oe_n && (!cs_n || !we_n), "R6 bus drive", {oe_n, cs_n, we_n}, 3'b100);
      if (req_ready) chk(cs_n && we_n && oe_n && !dq_oe, "R11 ready only when idle",
                         {cs_n, we_n, oe_n, dq_oe}, 4'b1110);
      // responses
      if (rsp_valid) begin
        bool_resp();
      end else if (due_q.size() > 0 && due_q[0] == cyc) begin
        chk(0, "R2 missing response", 0, 1);
        void'(due_q.pop_front()); void'(dat_q.pop_front());
      end
    end
  end

  task automatic bool_resp();
    if (due_q.size() == 0) begin
      chk(0, "R2 spurious response", 1, 0);
    end else begin
      int d = due_q.pop_front();
      logic [DW-1:0] e = dat_q.pop_front();
      chk(d == cyc, "R2 response edge", cyc, d);
      chk(rsp_rdata == e, "R2 read data", rsp_rdata, e);
    end
  endtask

  // present a request at a falling edge; returns the acceptance edge
  task automatic req(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input bit cs_style, output int acc);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; wr_cs_end = cs_style;
    while (1) begin
      #1;
      if (req_ready) break;
      @(negedge clk);
    end
    acc = cyc + 1;
    if (wr) begin
      exp_mem[a] = d;
      style_q.push_back(cs_style);
    end else begin
      due_q.push_back(acc + RD_CYC);
      dat_q.push_back(exp_mem.exists(a) ? exp_mem[a] : dflt(a));
    end
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_rsp(output int r);
    while (!rsp_valid) @(negedge clk);
    r = cyc;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int a0, a1, r0, d0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cs_n && we_n && oe_n && !dq_oe && !rsp_valid, "R1 pins in reset",
        {cs_n, we_n, oe_n, dq_oe, rsp_valid}, 5'b11100);
    rst_n = 1;
    @(negedge clk);
    chk(cs_n && we_n && oe_n && !dq_oe && !rsp_valid && req_ready, "R1 after reset",
        {cs_n, we_n, oe_n, dq_oe, rsp_valid, req_ready}, 6'b111001);

    // R4 write-enable-ended writes, back to back (R8)
    req(1, 18'h00010, 8'hA5, 0, a0);
    req(1, 18'h00011, 8'h3C, 0, a1);
    chk(a1 == a0 + WP_CYC + WT_CYC + 1, "R8 write occupancy", a1, a0 + WP_CYC + WT_CYC + 1);
    // R5 chip-select-ended writes at address boundaries
    req(1, 18'h00000, 8'h01, 1, a0);
    req(1, 18'h3FFFF, 8'hFE, 1, a1);
    chk(a1 == a0 + WP_CYC + WT_CYC + 1, "R8 write occupancy cs style", a1, a0 + WP_CYC + WT_CYC + 1);
    req(1, 18'h2AAAA, 8'h77, 0, a0);

    // R2 reads, back to back (R7)
    req(0, 18'h00010, 0, 0, a0);
    wait_rsp(r0);
    req(0, 18'h00011, 0, 0, a1);
    chk(a1 == r0 + 1, "R7 read after read", a1, r0 + 1);
    wait_rsp(r0);
    req(0, 18'h00000, 0, 0, a1);
    wait_rsp(r0);
    req(0, 18'h3FFFF, 0, 0, a1);
    wait_rsp(r0);
    req(0, 18'h12345, 0, 0, a1);
    wait_rsp(r0);
    // R7 read then write turnaround
    req(1, 18'h12345, 8'hC3, 1, a1);
    chk(a1 == r0 + TA_CYC + 1, "R7 write after read", a1, r0 + TA_CYC + 1);
    req(0, 18'h12345, 0, 0, a1);
    wait_rsp(r0);

    // R9 retention outranks a pending read
    @(negedge clk);
    ret_req = 1;
    req_valid = 1; req_write = 0; req_addr = 18'h2AAAA;
    for (int i = 0; i < 10; i++) begin
      #1;
      chk(!req_ready && cs_n && we_n && oe_n && !dq_oe, "R9 retention parked",
          {req_ready, cs_n, we_n, oe_n, dq_oe}, 5'b01110);
      @(negedge clk);
    end
    // R10 recovery before next access
    ret_req = 0;
    d0 = cyc;
    while (1) begin
      #1;
      if (req_ready) break;
      chk(cs_n, "R10 cs high during recovery", cs_n, 1);
      @(negedge clk);
    end
    a0 = cyc + 1;
    chk(a0 == d0 + REC_CYC + 2, "R10 recovery length", a0, d0 + REC_CYC + 2);
    due_q.push_back(a0 + RD_CYC);
    dat_q.push_back(exp_mem[18'h2AAAA]);
    @(negedge clk);
    req_valid = 0;
    wait_rsp(r0);

    // R9 retention raised during a write: write completes
    req(1, 18'h00555, 8'h99, 0, a0);
    ret_req = 1;
    repeat (8) @(negedge clk);
    chk(cs_n && !req_ready, "R9 parked after write", {cs_n, req_ready}, 2'b10);
    ret_req = 0;
    req(0, 18'h00555, 0, 0, a0);
    wait_rsp(r0);
    req(0, 18'h00011, 0, 0, a0);
    wait_rsp(r0);
    repeat (4) @(negedge clk);
    chk(due_q.size() == 0, "R2 all responses seen", due_q.size(), 0);
    finish_run();
  end
endmodule